// File: doc/BRIEF.md
# Speculative Frame-Group Allocator

This block keeps track of a shared pool of physical instruction frames for instruction blocks that are in flight at the same time. When a newly fetched block asks for space, it passes the frame count taken from the block's header. The allocator hands back a group ID and a base frame. The block then occupies a contiguous run of frames, counted modulo the pool size, that starts just after the youngest live group. A request is never split. If the run does not fit, the request waits until it does.

Live groups sit in a circular queue ordered by age. The oldest group is the only non-speculative one. When the completion input is raised, the oldest group is committed. Its frames are released and the next group in age order becomes the oldest. In keep-resident mode a commit leaves the group and its frames in place, so the same block can run again, as a repeated inner loop does. A mispredict names one live group. Every group younger than that one is squashed at once and its frames are reclaimed.

Group IDs are slot indices in the queue. They are handed out in increasing order, modulo the queue depth. The pool size and the queue depth must both be powers of two.

Top module: `frame_group_alloc`

## Requirements
- R1: After reset, no group is live, all 128 frames are free, `oldest_valid_o` is 0 and no grant, reject, commit or squash output is active.
- R2: A request for 1 to 16 frames that fits is granted in the same cycle. The group ID equals the previous grant's ID plus 1 modulo 32, and the first grant after reset gets ID 0. The base frame equals the end of the youngest live group modulo 128, and the first grant after reset gets base 0. The grant adds one live group and removes the requested count from the free frames.
- R3: A request whose count is larger than the number of free frames gets neither a grant nor a reject. It changes no state and is held until space opens up.
- R4: A request with a count of 0, or with a count from 17 to 31, raises `reject_o` in the same cycle and is never granted.
- R5: While 32 groups are live, a request is held with no grant.
- R6: A completion while at least one group is live, with keep-resident low, raises `commit_o` with the oldest group's ID and `commit_release_o` = 1. On the next cycle that group's frames are free and the next group in age order is the oldest.
- R7: A completion with keep-resident high raises `commit_o` with `commit_release_o` = 0. The live group count, the free frames and the oldest ID are all left unchanged.
- R8: A mispredict that names a live group raises `squash_o` whenever that group has younger groups. `squash_mask_o` has bit g set for each younger group ID g. Those groups and their frames are reclaimed on the next cycle, and the next grant starts at the frame just after the mispredicting group.
- R9: A mispredict that names a group ID which is not live has no effect on any output or state.
- R10: When a completion and a mispredict arrive in the same cycle, the younger groups are squashed first and the oldest group is still committed. This also holds when the mispredicting group is itself the oldest.
- R11: In a cycle with a completion or a mispredict input, an allocation request is neither granted nor rejected. It is held.
- R12: A completion while no group is live produces no commit and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Allocation request present |
| req_frames_i | input | 5 | Frame count from the block header |
| grant_o | output | 1 | Request granted this cycle |
| reject_o | output | 1 | Request count is illegal |
| grant_gid_o | output | 5 | Group ID of the grant |
| grant_base_o | output | 7 | First frame of the granted run |
| done_i | input | 1 | Oldest group has completed |
| keep_resident_i | input | 1 | Commit keeps the group mapped for re-execution |
| mispredict_i | input | 1 | Mispredict reported |
| mispredict_gid_i | input | 5 | Group that mispredicted |
| commit_o | output | 1 | Oldest group committed this cycle |
| commit_gid_o | output | 5 | ID of the committed group |
| commit_release_o | output | 1 | Committed group's frames are freed |
| squash_o | output | 1 | At least one group squashed this cycle |
| squash_mask_o | output | 32 | One bit per squashed group ID |
| oldest_valid_o | output | 1 | A live group exists |
| oldest_gid_o | output | 5 | ID of the non-speculative group |
| live_groups_o | output | 6 | Number of live groups |
| free_frames_o | output | 8 | Number of free frames |

## Verification
A completion of the oldest group and a mispredict can land in the same cycle, and an allocation request can be waiting in that cycle too. The bench provokes this once on purpose with the mispredicting group one step younger than the oldest, and keeps a fixed-seed random mix of both events running over many cycles, which also produces the case where the mispredicting group is the oldest. Each such cycle is judged against a bench model that squashes first and then commits. The model checks the squash mask, the commit ID, the free-frame count and live-group count on the following cycle, and checks that the waiting request was held.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam int DEF_FRAMES   = 128;
    localparam int DEF_MAX_GRP  = 16;
    localparam int DEF_MAX_LIVE = 32;

    typedef enum logic [1:0] {
        ALLOC_IDLE   = 2'd0,
        ALLOC_GRANT  = 2'd1,
        ALLOC_REJECT = 2'd2,
        ALLOC_HOLD   = 2'd3
    } alloc_res_e;
endpackage

// File: rtl/fg_alloc_gate.sv
// Decides what happens to an allocation request in the current cycle.
module fg_alloc_gate #(
    parameter int MAX_GRP  = 16,
    parameter int MAX_LIVE = 32,
    parameter int CNT_W    = 5,
    parameter int LIVE_W   = 6,
    parameter int FREE_W   = 8
) (
    input  logic              req_valid_i,
    input  logic [CNT_W-1:0]  req_frames_i,
    input  logic              hold_i,
    input  logic [FREE_W-1:0] free_i,
    input  logic [LIVE_W-1:0] live_i,
    output fg_pkg::alloc_res_e res_o
);
    localparam logic [CNT_W-1:0]  MAX_GRP_C  = CNT_W'(MAX_GRP);
    localparam logic [LIVE_W-1:0] MAX_LIVE_C = LIVE_W'(MAX_LIVE);

    logic illegal;
    logic fits;

    always_comb begin
        illegal = (req_frames_i == '0) || (req_frames_i > MAX_GRP_C);
        fits    = (FREE_W'(req_frames_i) <= free_i) && (live_i < MAX_LIVE_C);
        if (!req_valid_i) begin
            res_o = fg_pkg::ALLOC_IDLE;
        end else if (hold_i) begin
            res_o = fg_pkg::ALLOC_HOLD;
        end else if (illegal) begin
            res_o = fg_pkg::ALLOC_REJECT;
        end else if (fits) begin
            res_o = fg_pkg::ALLOC_GRANT;
        end else begin
            res_o = fg_pkg::ALLOC_HOLD;
        end
    end
endmodule

// File: rtl/fg_age_mask.sv
// Marks every live slot younger than the mispredicting slot.
module fg_age_mask #(
    parameter int MAX_LIVE = 32,
    parameter int GID_W    = 5,
    parameter int LIVE_W   = 6
) (
    input  logic [GID_W-1:0]    head_i,
    input  logic [LIVE_W-1:0]   live_i,
    input  logic                mis_valid_i,
    input  logic [GID_W-1:0]    mis_gid_i,
    output logic                in_range_o,
    output logic [GID_W-1:0]    mis_off_o,
    output logic [MAX_LIVE-1:0] mask_o
);
    assign mis_off_o  = mis_gid_i - head_i;
    assign in_range_o = mis_valid_i && ({1'b0, mis_off_o} < live_i);

    for (genvar s = 0; s < MAX_LIVE; s++) begin : g_slot
        logic [GID_W-1:0] age;
        assign age       = GID_W'(s) - head_i;
        assign mask_o[s] = in_range_o && (age > mis_off_o) && ({1'b0, age} < live_i);
    end
endmodule

// File: rtl/fg_reclaim_sum.sv
// Adds up the frame counts of the squashed slots.
module fg_reclaim_sum #(
    parameter int MAX_LIVE = 32,
    parameter int CNT_W    = 5,
    parameter int FREE_W   = 8
) (
    input  logic [MAX_LIVE-1:0]            mask_i,
    input  logic [MAX_LIVE-1:0][CNT_W-1:0] cnt_i,
    output logic [FREE_W-1:0]              sum_o
);
    always_comb begin
        sum_o = '0;
        for (int s = 0; s < MAX_LIVE; s++) begin
            if (mask_i[s]) begin
                sum_o = sum_o + FREE_W'(cnt_i[s]);
            end
        end
    end
endmodule

// File: rtl/frame_group_alloc.sv
module frame_group_alloc #(
    parameter int NUM_FRAMES = fg_pkg::DEF_FRAMES,
    parameter int MAX_GRP    = fg_pkg::DEF_MAX_GRP,
    parameter int MAX_LIVE   = fg_pkg::DEF_MAX_LIVE,
    localparam int FRAME_W   = $clog2(NUM_FRAMES),
    localparam int GID_W     = $clog2(MAX_LIVE),
    localparam int LIVE_W    = GID_W + 1,
    localparam int FREE_W    = $clog2(NUM_FRAMES + 1),
    localparam int CNT_W     = $clog2(MAX_GRP + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic [CNT_W-1:0]    req_frames_i,
    output logic                grant_o,
    output logic                reject_o,
    output logic [GID_W-1:0]    grant_gid_o,
    output logic [FRAME_W-1:0]  grant_base_o,
    input  logic                done_i,
    input  logic                keep_resident_i,
    input  logic                mispredict_i,
    input  logic [GID_W-1:0]    mispredict_gid_i,
    output logic                commit_o,
    output logic [GID_W-1:0]    commit_gid_o,
    output logic                commit_release_o,
    output logic                squash_o,
    output logic [MAX_LIVE-1:0] squash_mask_o,
    output logic                oldest_valid_o,
    output logic [GID_W-1:0]    oldest_gid_o,
    output logic [LIVE_W-1:0]   live_groups_o,
    output logic [FREE_W-1:0]   free_frames_o
);
    localparam logic [FREE_W-1:0] POOL_C = FREE_W'(NUM_FRAMES);

    typedef struct packed {
        logic [GID_W-1:0]                head;
        logic [GID_W-1:0]                tail;
        logic [LIVE_W-1:0]               live;
        logic [FREE_W-1:0]               used;
        logic [FRAME_W-1:0]              ftail;
        logic [MAX_LIVE-1:0][FRAME_W-1:0] base;
        logic [MAX_LIVE-1:0][CNT_W-1:0]   cnt;
    } state_t;

    state_t st_q, st_d;

    fg_pkg::alloc_res_e alloc_res;
    logic               mis_ok;
    logic [GID_W-1:0]   mis_off;
    logic [MAX_LIVE-1:0] sq_mask;
    logic [FREE_W-1:0]  reclaim;
    logic               event_cyc;
    logic               commit_fire;
    logic               release_fire;
    logic [FREE_W-1:0]  free_now;

    assign free_now     = POOL_C - st_q.used;
    assign event_cyc    = done_i || mispredict_i;
    assign commit_fire  = done_i && (st_q.live != '0);
    assign release_fire = commit_fire && !keep_resident_i;

    fg_alloc_gate #(
        .MAX_GRP (MAX_GRP),
        .MAX_LIVE(MAX_LIVE),
        .CNT_W   (CNT_W),
        .LIVE_W  (LIVE_W),
        .FREE_W  (FREE_W)
    ) u_gate (
        .req_valid_i (req_valid_i),
        .req_frames_i(req_frames_i),
        .hold_i      (event_cyc),
        .free_i      (free_now),
        .live_i      (st_q.live),
        .res_o       (alloc_res)
    );

    fg_age_mask #(
        .MAX_LIVE(MAX_LIVE),
        .GID_W   (GID_W),
        .LIVE_W  (LIVE_W)
    ) u_age (
        .head_i     (st_q.head),
        .live_i     (st_q.live),
        .mis_valid_i(mispredict_i),
        .mis_gid_i  (mispredict_gid_i),
        .in_range_o (mis_ok),
        .mis_off_o  (mis_off),
        .mask_o     (sq_mask)
    );

    fg_reclaim_sum #(
        .MAX_LIVE(MAX_LIVE),
        .CNT_W   (CNT_W),
        .FREE_W  (FREE_W)
    ) u_sum (
        .mask_i(sq_mask),
        .cnt_i (st_q.cnt),
        .sum_o (reclaim)
    );

    always_comb begin
        st_d = st_q;
        // squash of younger groups is applied before the commit
        if (mis_ok) begin
            st_d.tail  = mispredict_gid_i + GID_W'(1);
            st_d.live  = LIVE_W'(mis_off) + LIVE_W'(1);
            st_d.used  = st_q.used - reclaim;
            st_d.ftail = st_q.base[mispredict_gid_i] + FRAME_W'(st_q.cnt[mispredict_gid_i]);
        end
        if (release_fire) begin
            st_d.head = st_q.head + GID_W'(1);
            st_d.live = st_d.live - LIVE_W'(1);
            st_d.used = st_d.used - FREE_W'(st_q.cnt[st_q.head]);
        end
        if (alloc_res == fg_pkg::ALLOC_GRANT) begin
            st_d.base[st_q.tail] = st_q.ftail;
            st_d.cnt[st_q.tail]  = req_frames_i;
            st_d.tail            = st_q.tail + GID_W'(1);
            st_d.live            = st_q.live + LIVE_W'(1);
            st_d.used            = st_q.used + FREE_W'(req_frames_i);
            st_d.ftail           = st_q.ftail + FRAME_W'(req_frames_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o          = (alloc_res == fg_pkg::ALLOC_GRANT);
    assign reject_o         = (alloc_res == fg_pkg::ALLOC_REJECT);
    assign grant_gid_o      = st_q.tail;
    assign grant_base_o     = st_q.ftail;
    assign commit_o         = commit_fire;
    assign commit_gid_o     = st_q.head;
    assign commit_release_o = release_fire;
    assign squash_o         = |sq_mask;
    assign squash_mask_o    = sq_mask;
    assign oldest_valid_o   = (st_q.live != '0);
    assign oldest_gid_o     = st_q.head;
    assign live_groups_o    = st_q.live;
    assign free_frames_o    = free_now;
endmodule

// File: rtl/fg_alloc_chk.sv
module fg_alloc_chk #(
    parameter int MAX_LIVE = 32,
    parameter int LIVE_W   = 6,
    parameter int FREE_W   = 8,
    parameter int CNT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  req_frames_i,
    input logic              grant_o,
    input logic              reject_o,
    input logic              done_i,
    input logic              mispredict_i,
    input logic              commit_o,
    input logic              commit_release_o,
    input logic              squash_o,
    input logic [LIVE_W-1:0] live_groups_o,
    input logic [FREE_W-1:0] free_frames_o
);
    localparam logic [LIVE_W-1:0] FULL_C = LIVE_W'(MAX_LIVE);

    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && reject_o));

    assert_grant_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (FREE_W'(req_frames_i) <= free_frames_o));

    assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_groups_o == FULL_C) |-> !grant_o);

    assert_event_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i || mispredict_i) |-> (!grant_o && !reject_o));

    assert_grant_books_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> (live_groups_o == $past(live_groups_o) + LIVE_W'(1))
                 && (free_frames_o == $past(free_frames_o) - FREE_W'($past(req_frames_i))));

    assert_release_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && commit_release_o && !squash_o) |=> (free_frames_o > $past(free_frames_o)));

    assert_keep_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !commit_release_o && !squash_o) |=> ($stable(live_groups_o) && $stable(free_frames_o)));

    assert_squash_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> ((live_groups_o < $past(live_groups_o)) && (free_frames_o > $past(free_frames_o))));

    assert_quiet_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_o && !commit_o && !squash_o) |=> ($stable(live_groups_o) && $stable(free_frames_o)));
endmodule

bind frame_group_alloc fg_alloc_chk #(
    .MAX_LIVE(MAX_LIVE),
    .LIVE_W  (LIVE_W),
    .FREE_W  (FREE_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_frames_i    (req_frames_i),
    .grant_o         (grant_o),
    .reject_o        (reject_o),
    .done_i          (done_i),
    .mispredict_i    (mispredict_i),
    .commit_o        (commit_o),
    .commit_release_o(commit_release_o),
    .squash_o        (squash_o),
    .live_groups_o   (live_groups_o),
    .free_frames_o   (free_frames_o)
);

// File: tb/sim_frame_group_alloc.sv
module sim_frame_group_alloc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [4:0]  req_frames_i = '0;
    logic        done_i = 1'b0;
    logic        keep_resident_i = 1'b0;
    logic        mispredict_i = 1'b0;
    logic [4:0]  mispredict_gid_i = '0;
    logic        grant_o, reject_o, commit_o, commit_release_o, squash_o, oldest_valid_o;
    logic [4:0]  grant_gid_o, commit_gid_o, oldest_gid_o;
    logic [6:0]  grant_base_o;
    logic [31:0] squash_mask_o;
    logic [5:0]  live_groups_o;
    logic [7:0]  free_frames_o;

    int total = 0;
    int bad = 0;

    // bench model of the allocator
    int mbase[32];
    int mcnt[32];
    int mhead, mtail, mlive, mused, mftail;

    always #5 clk = ~clk;

    frame_group_alloc u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_frames_i(req_frames_i),
        .grant_o(grant_o), .reject_o(reject_o),
        .grant_gid_o(grant_gid_o), .grant_base_o(grant_base_o),
        .done_i(done_i), .keep_resident_i(keep_resident_i),
        .mispredict_i(mispredict_i), .mispredict_gid_i(mispredict_gid_i),
        .commit_o(commit_o), .commit_gid_o(commit_gid_o),
        .commit_release_o(commit_release_o),
        .squash_o(squash_o), .squash_mask_o(squash_mask_o),
        .oldest_valid_o(oldest_valid_o), .oldest_gid_o(oldest_gid_o),
        .live_groups_o(live_groups_o), .free_frames_o(free_frames_o)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    function automatic int age_of(input int gid);
        return (gid - mhead + 32) % 32;
    endfunction

    task automatic model_reset();
        mhead = 0; mtail = 0; mlive = 0; mused = 0; mftail = 0;
        for (int s = 0; s < 32; s++) begin
            mbase[s] = 0;
            mcnt[s]  = 0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid_i = 1'b0; done_i = 1'b0; mispredict_i = 1'b0; keep_resident_i = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive, compare all outputs with the model, advance the model.
    task automatic step(input bit av, input int ac, input bit d, input bit k,
                        input bit mv, input int mid, input string tag);
        bit    mis_ok, e_commit, e_rel, e_rej, e_grant, ev;
        int    moff, sum;
        logic [31:0] e_mask;
        @(negedge clk);
        req_valid_i = av; req_frames_i = 5'(ac);
        done_i = d; keep_resident_i = k;
        mispredict_i = mv; mispredict_gid_i = 5'(mid);
        #1;
        moff   = age_of(mid);
        mis_ok = mv && (moff < mlive);
        e_mask = '0;
        sum    = 0;
        for (int s = 0; s < 32; s++) begin
            if (mis_ok && age_of(s) > moff && age_of(s) < mlive) begin
                e_mask[s] = 1'b1;
                sum += mcnt[s];
            end
        end
        e_commit = d && (mlive > 0);
        e_rel    = e_commit && !k;
        ev       = d || mv;
        e_rej    = av && !ev && (ac == 0 || ac > 16);
        e_grant  = av && !ev && !e_rej && (mlive < 32) && (ac <= 128 - mused);

        chk(tag, "free_frames", free_frames_o, 128 - mused);
        chk(tag, "live_groups", live_groups_o, mlive);
        chk(tag, "oldest_valid", oldest_valid_o, mlive > 0);
        if (mlive > 0) chk(tag, "oldest_gid", oldest_gid_o, mhead);
        chk(tag, "grant", grant_o, e_grant);
        chk(tag, "reject", reject_o, e_rej);
        if (e_grant) begin
            chk(tag, "grant_gid", grant_gid_o, mtail);
            chk(tag, "grant_base", grant_base_o, mftail);
        end
        chk(tag, "commit", commit_o, e_commit);
        if (e_commit) begin
            chk(tag, "commit_gid", commit_gid_o, mhead);
            chk(tag, "commit_release", commit_release_o, e_rel);
        end
        chk(tag, "squash", squash_o, e_mask != 0);
        chk(tag, "squash_mask", squash_mask_o, e_mask);

        if (mis_ok) begin
            mtail  = (mid + 1) % 32;
            mlive  = moff + 1;
            mused  = mused - sum;
            mftail = (mbase[mid] + mcnt[mid]) % 128;
        end
        if (e_rel) begin
            mused = mused - mcnt[mhead];
            mhead = (mhead + 1) % 32;
            mlive = mlive - 1;
        end
        if (e_grant) begin
            mbase[mtail] = mftail;
            mcnt[mtail]  = ac;
            mtail  = (mtail + 1) % 32;
            mlive  = mlive + 1;
            mused  = mused + ac;
            mftail = (mftail + ac) % 128;
        end
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired got=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R1: reset state
        step(0, 0, 0, 0, 0, 0, "R1");
        chk("R1", "free_after_reset", free_frames_o, 128);
        chk("R1", "live_after_reset", live_groups_o, 0);

        // R2: first grants
        step(1, 16, 0, 0, 0, 0, "R2");
        step(1, 16, 0, 0, 0, 0, "R2");

        // R4: illegal counts
        step(1, 0, 0, 0, 0, 0, "R4");
        chk("R4", "reject_zero", reject_o, 1);
        step(1, 17, 0, 0, 0, 0, "R4");
        chk("R4", "reject_17", reject_o, 1);

        // fill the pool: ids 2..7
        for (int i = 0; i < 6; i++) step(1, 16, 0, 0, 0, 0, "R2");

        // R3: no space
        step(1, 1, 0, 0, 0, 0, "R3");
        chk("R3", "held_no_grant", grant_o, 0);
        step(0, 0, 0, 0, 0, 0, "R3");

        // R7: keep resident
        step(0, 0, 1, 1, 0, 0, "R7");
        chk("R7", "keep_release", commit_release_o, 0);
        step(0, 0, 0, 0, 0, 0, "R7");
        chk("R7", "keep_live", live_groups_o, 8);

        // R6: normal commit
        step(0, 0, 1, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, "R6");
        chk("R6", "oldest_after_commit", oldest_gid_o, 1);
        chk("R6", "free_after_commit", free_frames_o, 16);

        // R8: squash younger than id 3
        step(0, 0, 0, 0, 1, 3, "R8");
        chk("R8", "mask_ids_4_to_7", squash_mask_o, 32'h0000_00F0);
        step(1, 5, 0, 0, 0, 0, "R8");
        chk("R8", "base_after_squash", grant_base_o, 64);
        chk("R8", "gid_after_squash", grant_gid_o, 4);

        // R9: id not live
        step(0, 0, 0, 0, 1, 20, "R9");
        chk("R9", "no_squash", squash_o, 0);
        step(0, 0, 0, 0, 0, 0, "R9");

        // R10 and R11: completion, mispredict on id 2 and a request together
        step(1, 3, 1, 0, 1, 2, "R10");
        chk("R10", "mask_ids_3_4", squash_mask_o, 32'h0000_0018);
        chk("R11", "held_on_event", grant_o, 0);
        step(0, 0, 0, 0, 0, 0, "R10");
        chk("R10", "live_after_both", live_groups_o, 1);
        chk("R10", "oldest_after_both", oldest_gid_o, 2);
        chk("R10", "free_after_both", free_frames_o, 112);

        // R12: completion with nothing live
        step(0, 0, 1, 0, 0, 0, "R6");
        step(0, 0, 1, 0, 0, 0, "R12");
        chk("R12", "no_commit_empty", commit_o, 0);

        // R5: queue full
        do_reset();
        for (int i = 0; i < 32; i++) step(1, 1, 0, 0, 0, 0, "R2");
        step(1, 1, 0, 0, 0, 0, "R5");
        chk("R5", "full_no_grant", grant_o, 0);
        chk("R5", "full_live", live_groups_o, 32);

        // random mix, checked cycle by cycle against the model
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            bit av, d, k, mv;
            int ac, mid;
            av  = ($urandom % 100) < 65;
            ac  = (($urandom % 10) == 0) ? int'($urandom % 32) : 1 + int'($urandom % ((i % 500 < 250) ? 4 : 16));
            d   = ($urandom % 100) < 18;
            k   = ($urandom % 5) == 0;
            mv  = ($urandom % 100) < 7;
            mid = int'($urandom % 32);
            step(av, ac, d, k, mv, mid, (d && mv) ? "R10" : (mv ? "R8" : (d ? "R6" : "R2")));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule